// File: doc/BRIEF.md
# Sixteen-Opcode Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit processor core whose instructions can update four condition flags: negative (N), zero (Z), carry (C) and overflow (V). It receives a first operand and a second operand. The second operand comes either from the barrel shifter outside this block, together with that shifter's carry, or from an 8-bit constant that this block rotates itself. A 4-bit opcode picks one of sixteen operations. The block returns the 32-bit result, a destination write strobe and the next value of the four flags. Everything is combinational.

The core feeds the block once per executed data-processing instruction. Four of the opcodes are comparisons and tests: they only update the flags and never write the destination. The block also flags two encodings as invalid so that the core can raise an undefined-instruction trap. The first is a comparison or test whose set-flags bit is clear. The second is a set-flags request whose destination is the program counter.

Top module: `dp_alu`

## Requirements
- R1: Opcodes 0..15 compute, in order: a AND b, a XOR b, a-b, b-a, a+b, a+b+C, a-b-NOT C, b-a-NOT C, a AND b (test), a XOR b (test), a-b (compare), a+b (compare), a OR b, b, a AND NOT b, NOT b. Here b is the selected second operand and C is the stored carry flag. The `result` port always carries the computed value.
- R2: `write_en` is 1 for opcodes 0..7 and 12..15 and 0 for opcodes 8..11. It is also 0 whenever `invalid` is 1.
- R3: A subtraction computes x + NOT y + cin. C becomes the carry out of bit 31, so 1 means no borrow. cin is 1 for opcodes 2, 3 and 10, and is the stored C flag for opcodes 6 and 7.
- R4: An addition's cin is 0 for opcodes 4 and 11 and the stored C flag for opcode 5. C becomes the carry out of bit 31. The shifter carry never enters opcodes 2..7 or 10..11.
- R5: V for a subtraction x-y is 1 when x and y differ in sign and the result has the sign of y. V for an addition is 1 when both addends share a sign and the result's sign differs from it.
- R6: On a valid operation with `set_flags`=1, N equals result bit 31 and Z is 1 exactly when the result is zero. The flag vectors are packed as {N,Z,C,V}, with N in bit 3.
- R7: On the logical opcodes (0, 1, 8, 9, 12..15) with flags set, C takes the operand carry and V keeps its input value.
- R8: With `imm_sel`=1 the second operand is `imm_field[7:0]` rotated right by 2×`imm_field[11:8]`. The operand carry is bit 31 of the rotated value when that rotate field is nonzero, and the stored C flag when it is zero. With `imm_sel`=0 the operand is `op_b` and the operand carry is `shift_carry`.
- R9: `invalid` is 1 when the opcode is 8..11 with `set_flags`=0, or when `set_flags`=1 with `dest_is_pc`=1.
- R10: When `set_flags`=0 or `invalid`=1, `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand after the external shifter |
| shift_carry | input | 1 | Carry produced by the external shifter |
| imm_sel | input | 1 | Take the second operand from the rotated immediate |
| imm_field | input | 12 | Rotate count [11:8] and 8-bit constant [7:0] |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Update the flags from this operation |
| dest_is_pc | input | 1 | Destination register is the program counter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Computed value |
| write_en | output | 1 | Write result to the destination |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| invalid | output | 1 | Encoding is undefined |

## Verification
The assertions check the flag and write rules whenever the inputs change. They confirm that N and Z follow the result, that comparisons never write, that invalid or flag-less operations leave the flags alone, and that logical opcodes keep V. Only the bench's scenarios can show that the arithmetic is correct. That covers the result values, the carry and overflow at the signed and unsigned boundaries, the carry-in source for each opcode, and the immediate rotation with its carry rule.

// File: rtl/alu_pkg.sv
// Shared definitions for the data-processing ALU: opcode names and
// the packed flag vector layout {N,Z,C,V}.
package alu_pkg;
    localparam int DATA_W  = 32;
    localparam int IMM_W   = 8;
    localparam int ROT_W   = 4;
    localparam int FLAG_W  = 4;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSUB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC  = 4'd7,
        OP_TAND = 4'd8, OP_TXOR = 4'd9, OP_CSUB = 4'd10, OP_CADD = 4'd11,
        OP_OR  = 4'd12, OP_MOV = 4'd13, OP_ANDN = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    // True for opcodes that produce a result through the adder.
    function automatic logic is_arith(input logic [3:0] op);
        return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
    endfunction
endpackage

// File: rtl/alu_imm_rotator.sv
// Immediate operand builder: rotates an 8-bit constant right by twice
// the rotate field and yields the operand carry. Assumes the caller
// supplies the stored carry for the zero-rotation case.
module alu_imm_rotator #(
    parameter int DATA_W = alu_pkg::DATA_W,
    parameter int IMM_W  = alu_pkg::IMM_W,
    parameter int ROT_W  = alu_pkg::ROT_W
) (
    input  logic [ROT_W+IMM_W-1:0] imm_field,
    input  logic                   carry_prev,
    output logic [DATA_W-1:0]      imm_value,
    output logic                   imm_carry
);
    localparam int SH_W = ROT_W + 1;

    logic [DATA_W-1:0]   base;
    logic [2*DATA_W-1:0] doubled;
    logic [2*DATA_W-1:0] shifted;
    logic [SH_W-1:0]     amount;
    logic [ROT_W-1:0]    rot;

    // Rotate right by doubling the word and shifting the pair.
    always_comb begin
        rot       = imm_field[ROT_W+IMM_W-1:IMM_W];
        base      = {{(DATA_W-IMM_W){1'b0}}, imm_field[IMM_W-1:0]};
        amount    = {rot, 1'b0};
        doubled   = {base, base};
        shifted   = doubled >> amount;
        imm_value = shifted[DATA_W-1:0];
        imm_carry = (rot != '0) ? imm_value[DATA_W-1] : carry_prev;
    end
endmodule

// File: rtl/alu_arith.sv
// Adder/subtractor path for opcodes 2..7, 10 and 11. Picks operand
// order, carry-in and add/subtract from the opcode and produces the
// sum, carry out (1 = no borrow on subtract) and signed overflow.
module alu_arith #(
    parameter int DATA_W = alu_pkg::DATA_W
) (
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_stored,
    output logic [DATA_W-1:0] sum,
    output logic              carry_out,
    output logic              overflow
);
    import alu_pkg::*;

    logic [DATA_W-1:0] x, y, y_eff;
    logic              cin, sub;
    logic [DATA_W:0]   wide;

    // Operand order, carry-in and direction from the opcode.
    always_comb begin
        x   = a;
        y   = b;
        sub = 1'b0;
        cin = 1'b0;
        unique case (alu_op_e'(opcode))
            OP_SUB, OP_CSUB: begin sub = 1'b1; cin = 1'b1; end
            OP_RSUB:         begin x = b; y = a; sub = 1'b1; cin = 1'b1; end
            OP_SBC:          begin sub = 1'b1; cin = carry_stored; end
            OP_RSC:          begin x = b; y = a; sub = 1'b1; cin = carry_stored; end
            OP_ADC:          cin = carry_stored;
            default:         cin = 1'b0;
        endcase
    end

    // Single adder with inverted subtrahend, then overflow by sign rule.
    always_comb begin
        y_eff     = sub ? ~y : y;
        wide      = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, cin};
        sum       = wide[DATA_W-1:0];
        carry_out = wide[DATA_W];
        if (sub)
            overflow = (x[DATA_W-1] ^ y[DATA_W-1]) & ~(y[DATA_W-1] ^ sum[DATA_W-1]);
        else
            overflow = ~(x[DATA_W-1] ^ y[DATA_W-1]) & (y[DATA_W-1] ^ sum[DATA_W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
// Bitwise path for opcodes 0, 1, 8, 9 and 12..15. Assumes arithmetic
// opcodes are served elsewhere; returns zero for them.
module alu_logic #(
    parameter int DATA_W = alu_pkg::DATA_W
) (
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] value
);
    import alu_pkg::*;

    // Bitwise function select.
    always_comb begin
        unique case (alu_op_e'(opcode))
            OP_AND, OP_TAND: value = a & b;
            OP_XOR, OP_TXOR: value = a ^ b;
            OP_OR:           value = a | b;
            OP_MOV:          value = b;
            OP_ANDN:         value = a & ~b;
            OP_MVN:          value = ~b;
            default:         value = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
// Data-processing ALU top: selects the second operand (shifter or
// rotated immediate), runs the arithmetic and logic paths, and forms
// result, write strobe, next flags and the invalid-encoding indicator.
// Purely combinational; assumes the caller registers the outputs.
module dp_alu #(
    parameter int DATA_W = alu_pkg::DATA_W,
    parameter int IMM_W  = alu_pkg::IMM_W,
    parameter int ROT_W  = alu_pkg::ROT_W
) (
    input  logic [DATA_W-1:0]      op_a,
    input  logic [DATA_W-1:0]      op_b,
    input  logic                   shift_carry,
    input  logic                   imm_sel,
    input  logic [ROT_W+IMM_W-1:0] imm_field,
    input  logic [3:0]             opcode,
    input  logic                   set_flags,
    input  logic                   dest_is_pc,
    input  logic [3:0]             flags_in,
    output logic [DATA_W-1:0]      result,
    output logic                   write_en,
    output logic [3:0]             flags_out,
    output logic                   invalid
);
    import alu_pkg::*;

    alu_flags_t        fin, fout;
    logic [DATA_W-1:0] imm_value, operand, arith_sum, logic_val;
    logic              imm_carry, operand_carry, arith_c, arith_v;
    logic              arith_op, compare_op;

    assign fin = alu_flags_t'(flags_in);

    alu_imm_rotator #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
        .imm_field (imm_field),
        .carry_prev(fin.c),
        .imm_value (imm_value),
        .imm_carry (imm_carry)
    );

    // Second operand and its carry.
    always_comb begin
        operand       = imm_sel ? imm_value : op_b;
        operand_carry = imm_sel ? imm_carry : shift_carry;
    end

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .opcode      (opcode),
        .a           (op_a),
        .b           (operand),
        .carry_stored(fin.c),
        .sum         (arith_sum),
        .carry_out   (arith_c),
        .overflow    (arith_v)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .opcode(opcode),
        .a     (op_a),
        .b     (operand),
        .value (logic_val)
    );

    // Result merge, write strobe and invalid encodings.
    always_comb begin
        arith_op   = is_arith(opcode);
        compare_op = (opcode[3:2] == 2'b10);
        result     = arith_op ? arith_sum : logic_val;
        invalid    = (compare_op && !set_flags) || (set_flags && dest_is_pc);
        write_en   = !compare_op && !invalid;
    end

    // Next flags.
    always_comb begin
        fout = fin;
        if (set_flags && !invalid) begin
            fout.n = result[DATA_W-1];
            fout.z = (result == '0);
            fout.c = arith_op ? arith_c : operand_carry;
            fout.v = arith_op ? arith_v : fin.v;
        end
        flags_out = fout;
    end
endmodule

// File: rtl/dp_alu_checker.sv
// Property checker for dp_alu, attached by bind. Evaluated whenever
// the ALU ports change; assumes the ALU outputs settle combinationally.
module dp_alu_checker (
    input logic [31:0] result,
    input logic [3:0]  opcode,
    input logic        set_flags,
    input logic        dest_is_pc,
    input logic [3:0]  flags_in,
    input logic [3:0]  flags_out,
    input logic        write_en,
    input logic        invalid
);
    logic logical_op;

    // Port-level rule checks.
    always_comb begin
        logical_op = (opcode <= 4'd1) || opcode == 4'd8 || opcode == 4'd9 || opcode >= 4'd12;
        assert_compare_no_write_R2: assert (!(opcode[3:2] == 2'b10 && write_en))
            else $error("compare/test opcode wrote destination");
        assert_invalid_no_write_R2: assert (!(invalid && write_en))
            else $error("invalid encoding wrote destination");
        assert_invalid_cases_R9: assert (!(set_flags && dest_is_pc) || invalid)
            else $error("flag update to PC not invalid");
        assert_flags_hold_R10: assert (!(!set_flags || invalid) || flags_out == flags_in)
            else $error("flags changed without update");
        assert_nz_follow_R6: assert (!(set_flags && !invalid) ||
                                     (flags_out[3] == result[31] && flags_out[2] == (result == 32'd0)))
            else $error("N/Z disagree with result");
        assert_logic_keeps_v_R7: assert (!(set_flags && !invalid && logical_op) || flags_out[0] == flags_in[0])
            else $error("logical opcode changed V");
    end
endmodule

bind dp_alu dp_alu_checker u_chk (
    .result    (result),
    .opcode    (opcode),
    .set_flags (set_flags),
    .dest_is_pc(dest_is_pc),
    .flags_in  (flags_in),
    .flags_out (flags_out),
    .write_en  (write_en),
    .invalid   (invalid)
);

// File: tb/dp_alu_test.sv
module dp_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a, op_b, result;
    logic        shift_carry, imm_sel, set_flags, dest_is_pc, write_en, invalid;
    logic [11:0] imm_field;
    logic [3:0]  opcode, flags_in, flags_out;
    int          checks = 0;
    int          failures = 0;
    int          cycles = 0;

    always #5 clk = ~clk;

    dp_alu uut (
        .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry), .imm_sel(imm_sel),
        .imm_field(imm_field), .opcode(opcode), .set_flags(set_flags),
        .dest_is_pc(dest_is_pc), .flags_in(flags_in), .result(result),
        .write_en(write_en), .flags_out(flags_out), .invalid(invalid)
    );

    // Vector: opcode, a, b, flags_in, expected result, expected flags, expected write
    localparam int NV = 18;
    localparam logic [108:0] VEC [NV] = '{
        {4'd4,  32'h7FFFFFFF, 32'h00000001, 4'b0000, 32'h80000000, 4'b1001, 1'b1},
        {4'd4,  32'hFFFFFFFF, 32'h00000001, 4'b0000, 32'h00000000, 4'b0110, 1'b1},
        {4'd2,  32'h80000000, 32'h00000001, 4'b0000, 32'h7FFFFFFF, 4'b0011, 1'b1},
        {4'd2,  32'h00000000, 32'h00000001, 4'b0000, 32'hFFFFFFFF, 4'b1000, 1'b1},
        {4'd3,  32'h00000001, 32'h00000000, 4'b0000, 32'hFFFFFFFF, 4'b1000, 1'b1},
        {4'd5,  32'hFFFFFFFF, 32'h00000000, 4'b0010, 32'h00000000, 4'b0110, 1'b1},
        {4'd6,  32'h00000005, 32'h00000005, 4'b0000, 32'hFFFFFFFF, 4'b1000, 1'b1},
        {4'd7,  32'h00000001, 32'h80000000, 4'b0010, 32'h7FFFFFFF, 4'b0011, 1'b1},
        {4'd10, 32'h00000003, 32'h00000003, 4'b0000, 32'h00000000, 4'b0110, 1'b0},
        {4'd11, 32'h80000000, 32'h80000000, 4'b0000, 32'h00000000, 4'b0111, 1'b0},
        {4'd0,  32'hF0F0F0F0, 32'hFF00FF00, 4'b0001, 32'hF000F000, 4'b1001, 1'b1},
        {4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0000, 32'h00000000, 4'b0100, 1'b1},
        {4'd15, 32'h00000000, 32'h00000000, 4'b0000, 32'hFFFFFFFF, 4'b1000, 1'b1},
        {4'd9,  32'h12345678, 32'h12345678, 4'b0000, 32'h00000000, 4'b0100, 1'b0},
        {4'd12, 32'h00000001, 32'h00000002, 4'b0000, 32'h00000003, 4'b0000, 1'b1},
        {4'd1,  32'hFFFFFFFF, 32'h7FFFFFFF, 4'b0000, 32'h80000000, 4'b1000, 1'b1},
        {4'd13, 32'h00000000, 32'h7FFFFFFF, 4'b0000, 32'h7FFFFFFF, 4'b0000, 1'b1},
        {4'd8,  32'h00000001, 32'h00000002, 4'b0000, 32'h00000000, 4'b0100, 1'b0}
    };

    // Reference model from the requirements: returns {we, flags, result}.
    function automatic logic [36:0] ref_model(input logic [3:0] op, input logic [31:0] a,
                                              input logic [31:0] b, input logic sc,
                                              input logic [3:0] fi);
        logic [32:0] w;
        logic [31:0] r, x, y;
        logic        c, v, cin, isarith, issub;
        c = sc; v = fi[0]; r = '0; x = a; y = b; cin = 1'b0;
        isarith = 1'b1; issub = 1'b0;
        case (op)
            4'd0, 4'd8:  begin r = a & b; isarith = 1'b0; end
            4'd1, 4'd9:  begin r = a ^ b; isarith = 1'b0; end
            4'd2, 4'd10: begin issub = 1'b1; cin = 1'b1; end
            4'd3:        begin issub = 1'b1; cin = 1'b1; x = b; y = a; end
            4'd4, 4'd11: cin = 1'b0;
            4'd5:        cin = fi[1];
            4'd6:        begin issub = 1'b1; cin = fi[1]; end
            4'd7:        begin issub = 1'b1; cin = fi[1]; x = b; y = a; end
            4'd12:       begin r = a | b; isarith = 1'b0; end
            4'd13:       begin r = b; isarith = 1'b0; end
            4'd14:       begin r = a & ~b; isarith = 1'b0; end
            default:     begin r = ~b; isarith = 1'b0; end
        endcase
        if (isarith) begin
            if (issub) w = {1'b0, x} + {1'b0, ~y} + 33'(cin);
            else       w = {1'b0, x} + {1'b0, y} + 33'(cin);
            r = w[31:0];
            c = w[32];
            if (issub) v = (x[31] != y[31]) && (r[31] == y[31]);
            else       v = (x[31] == y[31]) && (r[31] != x[31]);
        end
        return {!(op >= 4'd8 && op <= 4'd11), r[31], r == 32'd0, c, v, r};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic [3:0] fi, input logic sf);
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; shift_carry = sc; flags_in = fi;
        set_flags = sf; imm_sel = 1'b0; dest_is_pc = 1'b0; imm_field = '0;
        #1;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [36:0] e;
        logic [31:0] bnd [5];
        bnd[0] = 32'h0; bnd[1] = 32'h1; bnd[2] = 32'h7FFFFFFF;
        bnd[3] = 32'h80000000; bnd[4] = 32'hFFFFFFFF;
        op_a = '0; op_b = '0; shift_carry = 0; imm_sel = 0; imm_field = '0;
        opcode = 4'd13; set_flags = 0; dest_is_pc = 0; flags_in = 4'b1010;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle state: MOV of zero without flag update holds flags (R10)
        check("R10 idle flags", {28'd0, flags_out}, 32'hA);
        check("R2 idle write", {31'd0, write_en}, 32'd1);

        // Vector table: R1 R3 R4 R5 R6 R7 R2
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][108:105], VEC[i][104:73], VEC[i][72:41], 1'b0, VEC[i][40:37], 1'b1);
            check("R1 table result", result, VEC[i][36:5]);
            check("R5 R6 table flags", {28'd0, flags_out}, {28'd0, VEC[i][4:1]});
            check("R2 table write", {31'd0, write_en}, {31'd0, VEC[i][0]});
        end

        // Reference sweep over every opcode and boundary pair (R1 R3 R4 R5 R7)
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int f = 0; f < 16; f += 5) begin
                        drive(4'(op), bnd[i], bnd[j], f[0], 4'(f), 1'b1);
                        e = ref_model(4'(op), bnd[i], bnd[j], f[0], 4'(f));
                        check("R1 sweep result", result, e[31:0]);
                        check("R3 R4 sweep flags", {28'd0, flags_out}, {28'd0, e[35:32]});
                        check("R2 sweep write", {31'd0, write_en}, {31'd0, e[36]});
                    end

        // R4: ADD ignores stored and shifter carry; ADC takes stored C, not shifter
        drive(4'd4, 32'd1, 32'd1, 1'b1, 4'b0010, 1'b1);
        check("R4 add no carry-in", result, 32'd2);
        drive(4'd5, 32'd1, 32'd1, 1'b1, 4'b0000, 1'b1);
        check("R4 adc stored carry", result, 32'd2);
        drive(4'd2, 32'd5, 32'd3, 1'b0, 4'b0000, 1'b1);
        check("R3 sub cin one", result, 32'd2);

        // R7: logical carry comes from shifter
        drive(4'd13, 32'd0, 32'd5, 1'b1, 4'b0001, 1'b1);
        check("R7 mov shifter carry", {28'd0, flags_out}, 32'b0011);

        // R8: immediate rotation
        drive(4'd13, 32'd0, 32'h1234, 1'b0, 4'b0000, 1'b1);
        imm_sel = 1'b1; imm_field = {4'd4, 8'hFF}; #1;
        check("R8 imm ror8 value", result, 32'hFF000000);
        check("R8 imm ror8 carry", {28'd0, flags_out}, 32'b1010);
        imm_field = {4'd1, 8'h01}; #1;
        check("R8 imm ror2 value", result, 32'h40000000);
        check("R8 imm ror2 carry", {28'd0, flags_out}, 32'b0000);
        flags_in = 4'b0010; shift_carry = 1'b0; imm_field = {4'd0, 8'h80}; #1;
        check("R8 imm rot0 value", result, 32'h00000080);
        check("R8 imm rot0 keeps C", {28'd0, flags_out}, 32'b0010);
        imm_field = {4'd15, 8'h03}; #1;
        check("R8 imm ror30 value", result, 32'h0000000C);

        // R9 R10: invalid encodings
        drive(4'd8, 32'hF, 32'hF, 1'b0, 4'b0101, 1'b0);
        check("R9 test without S", {31'd0, invalid}, 32'd1);
        check("R10 invalid keeps flags", {28'd0, flags_out}, 32'b0101);
        check("R2 invalid no write", {31'd0, write_en}, 32'd0);
        drive(4'd4, 32'd0, 32'd0, 1'b0, 4'b0000, 1'b1);
        dest_is_pc = 1'b1; #1;
        check("R9 flags to PC", {31'd0, invalid}, 32'd1);
        check("R10 PC keeps flags", {28'd0, flags_out}, 32'b0000);
        dest_is_pc = 1'b0; set_flags = 1'b0; #1;
        check("R9 plain add valid", {31'd0, invalid}, 32'd0);
        check("R10 no S keeps flags", {28'd0, flags_out}, 32'b0000);
        check("R2 plain add writes", {31'd0, write_en}, 32'd1);
        dest_is_pc = 1'b1; #1;
        check("R9 PC without S valid", {31'd0, invalid}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule